// File: doc/BRIEF.md
# Deserialized-Input Transfer Launch Controller

This block sits in front of a serial shift engine and decides when that engine starts sending a word taken from a set of parallel input pins. Two sources can start a transfer. The first is a change detector: it compares the live pin word with the last word sent. The second is an external trigger line. The block also picks which of eight transfer-attribute sets the serializer uses, and it drives six active-low peripheral select lines around each transfer.

A start is a one-cycle pulse on `start_o`. The word to send appears on `tx_word_o` in the same cycle. The same register is kept as the reference for the next comparison. While the shift engine reports busy, or a transfer is still open, no start is issued. A request that arrives in that time is remembered and is issued once the engine reports done. When the start finally goes out, it uses the pin word present at that moment. The select lines can be released at the end of each transfer, or held asserted until the next one.

Top module: `xfer_launch_ctl`

## Requirements
- R1: After reset, `start_o` is 0, `tx_word_o` (the compare register) is 0, `cs_n_o` is all ones (inactive), and no start is pending.
- R2: In master mode (`master_en`=1) with `chg_en`=1, a difference between `par_data` and the compare register raises `start_o` for one cycle, one clock after the difference is seen. This holds with `cfg_combined` at either 0 or 1.
- R3: At each start, the compare register takes the value of `par_data` from the launching cycle, and `tx_word_o` shows that value while `start_o` is high. While the pins stay equal to that value, no further change-triggered start occurs.
- R4: With `trig_en`=1, `cfg_combined`=0 and master mode, a rising edge on `ext_trig` gives exactly one start. That start comes on the third clock edge after the edge is first sampled, because the line passes through two synchronizer stages and one edge stage. With `cfg_combined`=1, the trigger is ignored.
- R5: No start is issued while `eng_busy` is high, or from a launch until `eng_done`. A change or trigger request that arrives in that time is held, and is issued after `eng_done` using the current `par_data`.
- R6: With `master_en`=0, or with the relevant enable (`chg_en` or `trig_en`) at 0, no start is issued.
- R7: On a start in master mode, `cs_n_o` becomes the bitwise inverse of `cs_pattern`: a 1 in bit i drives line i low (asserted), and a 0 leaves it high. On `eng_done` with `hold_cs_en`=0, every line returns high.
- R8: With `hold_cs_en`=1, `cs_n_o` keeps its pattern after `eng_done`, until the next start or until master mode is left.
- R9: In master mode, `attr_idx_o` equals `attr_sel`, with code n selecting set n for n = 0 to 7. In slave mode it is 1, whatever `attr_sel` holds.
- R10: In slave mode, `cs_n_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = master mode, 0 = slave mode |
| cfg_combined | input | 1 | 0 = deserialized-input configuration, 1 = combined configuration |
| chg_en | input | 1 | Enable start on data change |
| trig_en | input | 1 | Enable start on external trigger |
| hold_cs_en | input | 1 | Keep selects asserted after a transfer |
| attr_sel | input | 3 | Attribute set selection in master mode |
| cs_pattern | input | 6 | Select lines to assert (1 = assert) |
| par_data | input | 16 | Parallel word sampled from pins |
| ext_trig | input | 1 | Asynchronous external trigger |
| eng_busy | input | 1 | Shift engine busy |
| eng_done | input | 1 | Shift engine completion pulse |
| start_o | output | 1 | One-cycle start pulse |
| tx_word_o | output | 16 | Word to send (compare register) |
| attr_idx_o | output | 3 | Attribute set index |
| cs_n_o | output | 6 | Active-low peripheral selects |

## Verification
The change detector is exercised in several ways:
- a new pin word in each configuration;
- a word held steady after it has been sent, which separates a level compare from a one-shot launch;
- a word rewritten while the engine is busy, which shows whether a held request is dropped, sent early, or sent with stale data.

A long trigger pulse separates edge detection from level detection. The same trigger in the combined configuration shows whether the configuration gate is applied. Select patterns are checked with the hold enable at 0 and at 1, and the attribute index is swept over all eight codes in master mode, then checked once in slave mode.

// File: rtl/xfer_launch_ctl.sv
module xfer_launch_ctl #(
  parameter int DW         = 16,
  parameter int NCS        = 6,
  parameter int AW         = 3,
  parameter int SLAVE_ATTR = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           master_en,
  input  logic           cfg_combined,
  input  logic           chg_en,
  input  logic           trig_en,
  input  logic           hold_cs_en,
  input  logic [AW-1:0]  attr_sel,
  input  logic [NCS-1:0] cs_pattern,
  input  logic [DW-1:0]  par_data,
  input  logic           ext_trig,
  input  logic           eng_busy,
  input  logic           eng_done,
  output logic           start_o,
  output logic [DW-1:0]  tx_word_o,
  output logic [AW-1:0]  attr_idx_o,
  output logic [NCS-1:0] cs_n_o
);
  localparam logic [NCS-1:0] CS_IDLE = '1;

  logic          trig_s1, trig_s2, trig_s3;
  logic          pend_q, in_xfer_q, start_q;
  logic [DW-1:0] cmp_q;
  logic [NCS-1:0] cs_q;

  wire trig_rise = trig_s2 & ~trig_s3;
  wire trig_req  = master_en & trig_en & ~cfg_combined & trig_rise;
  wire chg_req   = master_en & chg_en & (par_data != cmp_q);
  wire eng_free  = ~eng_busy & ~in_xfer_q;
  wire launch    = master_en & eng_free & (trig_req | chg_req | pend_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {trig_s1, trig_s2, trig_s3} <= '0;
    else        {trig_s1, trig_s2, trig_s3} <= {ext_trig, trig_s1, trig_s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   pend_q <= 1'b0;
    else if (!master_en || launch) pend_q <= 1'b0;
    else if (trig_req || chg_req)  pend_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        in_xfer_q <= 1'b0;
    else if (launch)   in_xfer_q <= 1'b1;
    else if (eng_done) in_xfer_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_q <= 1'b0;
      cmp_q   <= '0;
    end else begin
      start_q <= launch;
      if (launch) cmp_q <= par_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                   cs_q <= CS_IDLE;
    else if (!master_en)                          cs_q <= CS_IDLE;
    else if (launch)                              cs_q <= ~cs_pattern;
    else if (eng_done && in_xfer_q && !hold_cs_en) cs_q <= CS_IDLE;

  assign start_o    = start_q;
  assign tx_word_o  = cmp_q;
  assign cs_n_o     = cs_q;
  assign attr_idx_o = master_en ? attr_sel : AW'(SLAVE_ATTR);

  // R5
  busy_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> !start_o);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R3
  word_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> tx_word_o == $past(par_data));

  // R6
  master_only_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(master_en));

  // R10
  slave_cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> cs_n_o == CS_IDLE);

  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && in_xfer_q && !hold_cs_en) |=> cs_n_o == CS_IDLE);
endmodule

// File: tb/xfer_launch_ctl_tb_top.sv
`timescale 1ns/1ps
module xfer_launch_ctl_tb_top;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic master_en = 0, cfg_combined = 0, chg_en = 0, trig_en = 0, hold_cs_en = 0;
  logic [2:0] attr_sel = 0;
  logic [5:0] cs_pattern = 0;
  logic [DW-1:0] par_data = 0;
  logic ext_trig = 0;
  logic eng_busy, eng_done;
  logic start_o;
  logic [DW-1:0] tx_word_o;
  logic [2:0] attr_idx_o;
  logic [5:0] cs_n_o;

  int checks = 0, errors = 0, nstart = 0;
  logic [DW-1:0] exp_q[$];
  int eng_cnt = 0;

  always #4 clk = ~clk;

  xfer_launch_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .cfg_combined(cfg_combined),
    .chg_en(chg_en), .trig_en(trig_en), .hold_cs_en(hold_cs_en), .attr_sel(attr_sel),
    .cs_pattern(cs_pattern), .par_data(par_data), .ext_trig(ext_trig),
    .eng_busy(eng_busy), .eng_done(eng_done), .start_o(start_o),
    .tx_word_o(tx_word_o), .attr_idx_o(attr_idx_o), .cs_n_o(cs_n_o));

  assign eng_busy = (eng_cnt != 0);
  assign eng_done = (eng_cnt == 1);

  always @(posedge clk)
    if (start_o) eng_cnt <= 4;
    else if (eng_cnt > 0) eng_cnt <= eng_cnt - 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_word(input logic [DW-1:0] w);
    exp_q.push_back(w);
  endtask

  always @(negedge clk)
    if (rst_n && start_o) begin
      nstart++;
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected start", {16'h0, tx_word_o}, 32'h0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(tx_word_o == e, "R3 sent word", {16'h0, tx_word_o}, {16'h0, e});
      end
    end

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    chk(start_o == 0, "R1 start", start_o, 0);
    chk(tx_word_o == 0, "R1 compare", tx_word_o, 0);
    chk(cs_n_o == 6'h3f, "R1 cs", cs_n_o, 6'h3f);
    rst_n = 1;
    @(negedge clk);
    chk(attr_idx_o == 3'd1, "R9 slave index", attr_idx_o, 1);
    chk(cs_n_o == 6'h3f, "R10 slave cs", cs_n_o, 6'h3f);

    // R6: slave mode, change enabled, data differs -> nothing
    chg_en = 1; par_data = 16'h0042;
    settle();
    chk(nstart == 0, "R6 slave no start", nstart, 0);

    // R9 sweep
    master_en = 1; chg_en = 0;
    for (int i = 0; i < 8; i++) begin
      attr_sel = 3'(i);
      @(negedge clk);
      chk(attr_idx_o == 3'(i), "R9 master index", attr_idx_o, i);
    end
    master_en = 0; attr_sel = 3'd6;
    @(negedge clk);
    chk(attr_idx_o == 3'd1, "R9 slave ignores field", attr_idx_o, 1);

    // R6: master, change disabled, data differs
    master_en = 1;
    settle();
    chk(nstart == 0, "R6 chg disabled", nstart, 0);

    // R2/R7: change detect, deserialized config
    cs_pattern = 6'b100101; s0 = nstart;
    par_data = 16'hA5A5; expect_word(16'hA5A5); chg_en = 1;
    @(negedge clk);
    chk(start_o == 1, "R2 start one cycle after change", start_o, 1);
    chk(cs_n_o == 6'b011010, "R7 cs pattern", cs_n_o, 6'b011010);
    settle();
    chk(cs_n_o == 6'h3f, "R7 cs released", cs_n_o, 6'h3f);
    chk(nstart == s0 + 1, "R3 no restart while equal", nstart, s0 + 1);

    // R5: change while busy is held and sent with current data
    s0 = nstart;
    par_data = 16'h1111; expect_word(16'h1111);
    @(negedge clk); @(negedge clk);
    par_data = 16'h2222;
    @(negedge clk);
    chk(start_o == 0, "R5 no start while busy", start_o, 0);
    par_data = 16'h3333; expect_word(16'h3333);
    settle();
    chk(nstart == s0 + 2, "R5 pending issued", nstart, s0 + 2);
    chk(tx_word_o == 16'h3333, "R3 compare holds sent word", tx_word_o, 16'h3333);

    // R2: combined configuration, change detect
    cfg_combined = 1; s0 = nstart;
    par_data = 16'h4444; expect_word(16'h4444);
    settle();
    chk(nstart == s0 + 1, "R2 combined config", nstart, s0 + 1);

    // R4: trigger ignored in combined configuration
    chg_en = 0; trig_en = 1; s0 = nstart;
    par_data = 16'h5555;
    ext_trig = 1; repeat (5) @(negedge clk); ext_trig = 0;
    settle();
    chk(nstart == s0, "R4 trigger ignored combined", nstart, s0);

    // R4: trigger in deserialized configuration, long pulse -> one start
    cfg_combined = 0; s0 = nstart;
    expect_word(16'h5555);
    ext_trig = 1;
    @(negedge clk); @(negedge clk);
    chk(start_o == 0, "R4 not before third edge", start_o, 0);
    @(negedge clk);
    chk(start_o == 1, "R4 start on third edge", start_o, 1);
    repeat (4) @(negedge clk); ext_trig = 0;
    settle();
    chk(nstart == s0 + 1, "R4 one start per edge", nstart, s0 + 1);

    // R8: hold selects after done
    trig_en = 0; chg_en = 1; hold_cs_en = 1; cs_pattern = 6'b000011;
    par_data = 16'h6666; expect_word(16'h6666);
    settle();
    chk(cs_n_o == 6'b111100, "R8 cs held", cs_n_o, 6'b111100);
    master_en = 0;
    @(negedge clk); @(negedge clk);
    chk(cs_n_o == 6'h3f, "R10 cs idle in slave", cs_n_o, 6'h3f);

    settle();
    chk(exp_q.size() == 0, "R3 all expected starts seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule